// File: doc/BRIEF.md
# Search Identifier Responder (Node Side)

This block is the node end of a bit-by-bit elimination search over a fixed identifier on a shared open-drain line. Any participant can pull the line low, so a low level always wins. The analog slot timing is handled elsewhere and arrives here as one request per slot. Each request says one of three things: send the identifier bit, send its inverse, or take the bit the master has chosen.

The node walks through its identifier starting at bit 0. For each position it answers one true slot, then one inverse slot, then takes one write slot. To send a 0 it pulls the line low; to send a 1 it releases the line. If the written value does not equal the node's own bit at that position, the node drops out and stays silent until the search is restarted. A node that matches at every position through the top bit raises a selected flag. A synchronous start input and the asynchronous reset both restart the search.

Top module: `search_responder`

## Requirements
- R1: After reset or a start pulse, `active` is 1, `selected` is 0, `bitIndex` is 0 and `driveLow` is 0. The next slot expected is a true slot.
- R2: The slot kind codes are 0 = send true bit, 1 = send inverse bit, 2 = take written bit, and 3 = none. When a node is active and not yet selected and a kind-0 slot comes in the true phase, `driveLow` equals the inverse of `idValue[bitIndex]` in that same cycle. Bit 0 is served first.
- R3: When a node is active and not yet selected and a kind-1 slot comes in the inverse phase, `driveLow` equals `idValue[bitIndex]` in that same cycle.
- R4: A kind-2 slot in the take phase whose `writeBit` equals `idValue[bitIndex]`, below the top position, raises `bitIndex` by one on the next edge. `driveLow` stays 0 during that slot, and the following expected slot is a true slot.
- R5: A kind-2 slot in the take phase whose `writeBit` differs from `idValue[bitIndex]` clears `active` on the next edge. `active` then stays 0 until reset or start.
- R6: While `active` is 0, `driveLow` is 0 whatever the slot inputs are, and `bitIndex` does not change.
- R7: A slot whose kind is not the one the current phase expects (including kind 3) is ignored. It causes no drive, no phase change and no index change.
- R8: A matching write at position ID_BITS-1 sets `selected` on the next edge. `active` stays 1 and `bitIndex` stays at ID_BITS-1. While `selected` is 1, every slot is ignored and `driveLow` stays 0 until reset or start.
- R9: A start pulse brings an inactive or selected node back to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous restart of the search |
| slotValid | input | 1 | A slot request is present this cycle |
| slotKind | input | 2 | Slot kind: 0 true, 1 inverse, 2 write, 3 none |
| writeBit | input | 1 | Bit written by the master in a write slot |
| idValue | input | ID_BITS | Node identifier, bit 0 served first |
| driveLow | output | 1 | Pull the shared line low in this slot |
| active | output | 1 | Node is still in the search |
| bitIndex | output | IDX_W | Identifier position being served |
| selected | output | 1 | Node matched at every position |

## Verification
The assertions assume that `idValue` stays constant during a search. They also assume that `start` and slot requests are never presented in the same cycle. The stimulus sets the identifier only while `start` is being pulsed. It drives each slot for exactly one cycle with `start` held low, and it clears `slotValid` between slots. Within those limits it sweeps every possible drop-out position, and it also injects out-of-phase and kind-3 requests at several points in the sequence.

// File: rtl/search_pkg.sv
package search_pkg;
  typedef enum logic [1:0] {
    SLOT_TRUE  = 2'd0,
    SLOT_COMP  = 2'd1,
    SLOT_WRITE = 2'd2,
    SLOT_NONE  = 2'd3
  } slotKindT;

  typedef enum logic [1:0] {
    PH_TRUE = 2'd0,
    PH_COMP = 2'd1,
    PH_RECV = 2'd2
  } phaseT;

  typedef struct packed {
    logic sendTrue;
    logic sendComp;
    logic clearIdx;
    logic stepIdx;
  } strobeT;
endpackage

// File: rtl/search_ctrl.sv
module search_ctrl
  import search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       slotValid,
  input  logic [1:0] slotKind,
  input  logic       writeBit,
  input  logic       curBit,
  input  logic       lastBit,
  output logic       active,
  output logic       selected,
  output strobeT     strobe
);
  phaseT phase;
  logic engaged, wrSlot, mismatch;

  assign engaged  = slotValid && active && !selected && !start;
  assign wrSlot   = engaged && (phase == PH_RECV) && (slotKind == SLOT_WRITE);
  assign mismatch = writeBit != curBit;

  always_comb begin
    strobe          = '0;
    strobe.clearIdx = start;
    if (engaged) begin
      strobe.sendTrue = (phase == PH_TRUE) && (slotKind == SLOT_TRUE);
      strobe.sendComp = (phase == PH_COMP) && (slotKind == SLOT_COMP);
    end
    strobe.stepIdx = wrSlot && !mismatch && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_TRUE;
      active   <= 1'b1;
      selected <= 1'b0;
    end else if (start) begin
      phase    <= PH_TRUE;
      active   <= 1'b1;
      selected <= 1'b0;
    end else if (engaged) begin
      unique case (phase)
        PH_TRUE: if (slotKind == SLOT_TRUE) phase <= PH_COMP;
        PH_COMP: if (slotKind == SLOT_COMP) phase <= PH_RECV;
        default: if (slotKind == SLOT_WRITE) begin
          phase <= PH_TRUE;
          if (mismatch)     active   <= 1'b0;
          else if (lastBit) selected <= 1'b1;
        end
      endcase
    end
  end

  p_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrSlot && mismatch) |=> !active);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !start) |=> !active);
  p_select_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !start) |=> (selected && active));
  p_one_send_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sendTrue && strobe.sendComp));
endmodule

// File: rtl/search_dp.sv
module search_dp
  import search_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int IDX_W   = $clog2(ID_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [ID_BITS-1:0] idValue,
  output logic               curBit,
  output logic               lastBit,
  output logic               driveLow,
  output logic [IDX_W-1:0]   bitIndex
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);

  assign curBit   = idValue[bitIndex];
  assign lastBit  = bitIndex == LAST_IDX;
  assign driveLow = (strobe.sendTrue && !curBit) || (strobe.sendComp && curBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitIndex <= '0;
    else if (strobe.clearIdx) bitIndex <= '0;
    else if (strobe.stepIdx)  bitIndex <= bitIndex + 1'b1;
  end

  p_index_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearIdx && !strobe.stepIdx) |=> $stable(bitIndex));
endmodule

// File: rtl/search_responder.sv
module search_responder
  import search_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int IDX_W   = $clog2(ID_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               slotValid,
  input  logic [1:0]         slotKind,
  input  logic               writeBit,
  input  logic [ID_BITS-1:0] idValue,
  output logic               driveLow,
  output logic               active,
  output logic [IDX_W-1:0]   bitIndex,
  output logic               selected
);
  strobeT strobe;
  logic   curBit, lastBit;

  search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .slotValid(slotValid),
    .slotKind(slotKind), .writeBit(writeBit), .curBit(curBit),
    .lastBit(lastBit), .active(active), .selected(selected), .strobe(strobe)
  );

  search_dp #(.ID_BITS(ID_BITS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idValue(idValue),
    .curBit(curBit), .lastBit(lastBit), .driveLow(driveLow), .bitIndex(bitIndex)
  );

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !driveLow);
  p_quiet_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> !driveLow);
  p_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (active && !selected && bitIndex == '0));
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && !selected && !start && slotValid && slotKind == SLOT_WRITE &&
     writeBit == idValue[bitIndex] && bitIndex != IDX_W'(ID_BITS - 1) &&
     !driveLow && $past(slotValid && slotKind == SLOT_COMP))
    |=> bitIndex == $past(bitIndex) + 1'b1);
endmodule

// File: tb/search_responder_test.sv
`timescale 1ns/100ps
module search_responder_test;
  localparam int N = 64;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, slotValid = 1'b0, writeBit = 1'b0;
  logic [1:0] slotKind = 2'd3;
  logic [N-1:0] idValue = '0;
  logic driveLow, active, selected;
  logic [W-1:0] bitIndex;

  int checks = 0, errors = 0, cycles = 0;
  logic mActive, mSel;
  int mIdx, mPhase;

  always #2 clk = ~clk;

  search_responder #(.ID_BITS(N)) uut (
    .clk(clk), .rstN(rstN), .start(start), .slotValid(slotValid),
    .slotKind(slotKind), .writeBit(writeBit), .idValue(idValue),
    .driveLow(driveLow), .active(active), .bitIndex(bitIndex), .selected(selected)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    check(active == mActive, {tag, " active"}, active, mActive);
    check(selected == mSel, {tag, " selected"}, selected, mSel);
    check(bitIndex == W'(mIdx), {tag, " bitIndex"}, bitIndex, mIdx);
  endtask

  task automatic doStart(input logic [N-1:0] id, input string tag);
    @(negedge clk);
    start = 1'b1; idValue = id;
    @(posedge clk);
    #1 start = 1'b0;
    mActive = 1'b1; mSel = 1'b0; mIdx = 0; mPhase = 0;
    checkState(tag);
    check(driveLow == 1'b0, {tag, " driveLow"}, driveLow, 0);
  endtask

  task automatic doSlot(input logic [1:0] kind, input logic wb);
    logic match, expDrive;
    string tag;
    @(negedge clk);
    slotValid = 1'b1; slotKind = kind; writeBit = wb;
    match = mActive && !mSel && (int'(kind) == mPhase);
    expDrive = match && kind != 2'd2 && ((kind == 2'd0) ? !idValue[mIdx] : idValue[mIdx]);
    if (!mActive) tag = "R6";
    else if (mSel) tag = "R8";
    else if (!match) tag = "R7";
    else if (kind == 2'd0) tag = "R2";
    else if (kind == 2'd1) tag = "R3";
    else tag = "R4";
    #1 check(driveLow == expDrive, {tag, " driveLow"}, driveLow, expDrive);
    if (match) begin
      if (kind == 2'd0) mPhase = 1;
      else if (kind == 2'd1) mPhase = 2;
      else begin
        mPhase = 0;
        if (wb != idValue[mIdx]) begin mActive = 1'b0; tag = "R5"; end
        else if (mIdx == N - 1) begin mSel = 1'b1; tag = "R8"; end
        else mIdx++;
      end
    end
    @(posedge clk);
    #1 slotValid = 1'b0; slotKind = 2'd3;
    checkState(tag);
  endtask

  task automatic doBit(input logic wb);
    doSlot(2'd0, 1'b0);
    doSlot(2'd1, 1'b0);
    doSlot(2'd2, wb);
  endtask

  initial begin
    mActive = 1'b1; mSel = 1'b0; mIdx = 0; mPhase = 0;
    #1;
    check(driveLow == 1'b0, "R1 driveLow in reset", driveLow, 0);
    #6 rstN = 1'b1;
    #1 checkState("R1");

    // full matching searches over several identifiers
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] id;
      id = {8'hB3 ^ 8'(p * 37), 48'h1234_5678_9ABC * 64'(p + 1), 8'hFD};
      if (p == 3) id = ~'0;
      if (p == 2) id = '0;
      doStart(id, "R1");
      doSlot(2'd2, 1'b0);  // R7 write in true phase
      doSlot(2'd1, 1'b0);  // R7 inverse in true phase
      doSlot(2'd3, 1'b0);  // R7 none
      for (int b = 0; b < N; b++) begin
        if (b % 17 == 5) doSlot(2'd3, 1'b1);
        doSlot(2'd0, 1'b0);
        if (b % 13 == 2) doSlot(2'd0, 1'b0);  // R7 repeat true
        doSlot(2'd1, 1'b0);
        if (b % 11 == 3) doSlot(2'd0, 1'b0);  // R7 true in take phase
        doSlot(2'd2, idValue[b]);
      end
      check(selected == 1'b1, "R8 selected after last bit", selected, 1);
      doBit(1'b0);  // R8 ignored after selection
      doBit(1'b1);
    end

    // drop-out at every position, then silence and restart
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] id;
      id = 64'hA5C3_0F96_3C5A_F00F ^ (64'h1 << k) ^ 64'(k * 131);
      doStart(id, k[0] ? "R9" : "R1");
      for (int b = 0; b < k; b++) doBit(idValue[b]);
      doBit(!idValue[k]);
      check(active == 1'b0, "R5 dropped", active, 0);
      for (int b = 0; b < 2; b++) doBit(1'b0);
      doSlot(2'd0, 1'b0);
      doSlot(2'd1, 1'b0);
      doSlot(2'd3, 1'b1);
    end
    doStart('0, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule